// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block works next to a small 8-bit processor core and takes over the bus work of entering and leaving interrupt handlers. Each cycle it looks at the hardware interrupt sources: an external interrupt latch and two timer flags (overflow and real-time tick), each with its own enable. A global mask bit in the core's condition code byte gates them. The core's decoder can also present a software interrupt or a return-from-interrupt command on a valid/ready handshake.

When a request is taken, the block pushes five context bytes onto a downward-growing stack held in a 32-byte RAM window. It then reads the source's 16-bit vector from a fixed byte pair, and it ends with a one-cycle completion pulse that carries the new program counter and the new condition code byte. A return pops the five bytes in reverse and hands the restored A, X, condition code and program counter back to the core. Out of reset, it fetches the reset vector and loads the program counter before it accepts anything else.

Memory traffic uses one request/ready channel. The block drives a write or read strobe with an address, and with write data for writes. A transfer happens on a rising clock edge where the strobe and `mem_ready` are both high, and read data is taken in that same cycle. While `mem_ready` is low, the block holds the strobe, address and data unchanged. On the command side, `cmd_ready` is high only when the block is idle and no unmasked hardware request is pending. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high, and the decoder must hold it until then.

Top module: `irq_stack_seq`

## Requirements
- R1: Reset sets the stack pointer to 0xFF. After reset the block reads 0x3FE and then 0x3FF with no writes, and pulses `done` with `pc_new` = {byte at 0x3FE, byte at 0x3FF}. `ccr_wr` and `ax_wr` stay low during this pulse.
- R2: When the block is idle, an unmasked external request wins over an unmasked timer request, and either one wins over a command presented in the same cycle. The vector pairs are: external at 0x3FA/0x3FB, timer at 0x3F8/0x3F9, software interrupt at 0x3FC/0x3FD. The high byte comes from the even address and is read first.
- R3: When `ccr_in` bit 3 (the global mask) is 1, external and timer requests are not taken. A software interrupt command is still accepted.
- R4: An external request exists only when `ext_flag` and `ext_en` are both 1. A timer request exists when (`ovf_flag` and `ovf_en`) or (`rt_flag` and `rt_en`).
- R5: On entry, five bytes are written in this order: PC low, PC high, X, A, CCR. Each byte is written to address 0x00 concatenated with the stack pointer, and the pointer decrements after each write. The values are those of `pc_in`, `x_in`, `a_in` and `ccr_in` at acceptance.
- R6: An entry ends with a one-cycle `done` pulse in the cycle after the vector low-byte read. In that pulse, `pc_new` is the vector, `ccr_wr` is 1, and `ccr_new` is the saved CCR with bit 3 set.
- R7: A return increments the stack pointer before each of five reads and takes the bytes in this order: CCR, A, X, PC high, PC low. Its `done` pulse shows `ccr_wr` = `ax_wr` = 1, with the popped values on `ccr_new`, `a_new`, `x_new` and `pc_new`.
- R8: The stack pointer always stays in 0xE0..0xFF and wraps inside that window in both directions.
- R9: At most one transfer happens per clock, and the write and read strobes are never high together. While `mem_ready` is low, the strobes, address and write data hold steady, and the frame content does not change.
- R10: `ext_clr` pulses for exactly one cycle when an external request is taken, and at no other time.
- R11: While the block is busy, `cmd_ready` is low and no new request is taken. A request that appears during a sequence does not interrupt it, even if the mask is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_flag | input | 1 | External interrupt latch |
| ext_en | input | 1 | External interrupt enable |
| ovf_flag | input | 1 | Timer overflow flag |
| ovf_en | input | 1 | Timer overflow enable |
| rt_flag | input | 1 | Real-time tick flag |
| rt_en | input | 1 | Real-time tick enable |
| cmd_valid | input | 1 | Decoder presents a command |
| cmd_rti | input | 1 | Command kind: 1 return, 0 software interrupt |
| cmd_ready | output | 1 | Command accepted on this edge if valid |
| ccr_in | input | 8 | Current condition code byte (bit 3 = mask) |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current index register |
| pc_in | input | 16 | Program counter to save |
| mem_wr | output | 1 | Write strobe |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 16 | Transfer address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, same cycle |
| mem_ready | input | 1 | Memory accepts the transfer |
| busy | output | 1 | A sequence is in progress |
| sp_out | output | 8 | Stack pointer |
| ext_clr | output | 1 | Clear pulse for the external latch |
| done | output | 1 | Completion pulse |
| pc_new | output | 16 | Program counter to load |
| ccr_wr | output | 1 | Load `ccr_new` into the core |
| ccr_new | output | 8 | New condition code byte |
| ax_wr | output | 1 | Load `a_new` and `x_new` into the core |
| a_new | output | 8 | Restored accumulator |
| x_new | output | 8 | Restored index register |

## Verification
Checks in the RTL run on every cycle. They cover the exclusive bus strobes and the stable request under back-pressure, and they keep stack writes and the stack pointer inside the RAM window. They also cover the single-cycle completion pulse, the mask bit set on every entry, and the rule that nothing is accepted while busy.

Some behaviour only the bench scenarios can show: priority among simultaneous sources, the effect of the mask and the local enables, the exact byte order and addresses of the push and pop frames, and vector selection. Two more need long multi-step runs: the wrap of nested frames across the window edge, and the fact that a request raised mid-sequence is not taken.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_PUSH, ST_POP, ST_VHI, ST_VLO, ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {OP_RESET, OP_ENTRY, OP_RETURN} seq_op_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_EXT, SRC_TMR} hw_src_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] EXT_VEC = 16'h03FA,
  parameter logic [15:0] TMR_VEC = 16'h03F8
) (
  input  logic              ext_flag,
  input  logic              ext_en,
  input  logic              ovf_flag,
  input  logic              ovf_en,
  input  logic              rt_flag,
  input  logic              rt_en,
  input  logic              gmask,
  output logic              take,
  output hw_src_e           src,
  output logic [ADDR_W-1:0] vec
);
  logic ext_req, tmr_req;

  assign ext_req = ext_flag & ext_en;
  assign tmr_req = (ovf_flag & ovf_en) | (rt_flag & rt_en);
  assign take    = !gmask && (ext_req || tmr_req);

  // fixed order: external before timer
  always_comb begin
    src = SRC_NONE;
    vec = ADDR_W'(TMR_VEC);
    if (!gmask && ext_req) begin
      src = SRC_EXT;
      vec = ADDR_W'(EXT_VEC);
    end else if (!gmask && tmr_req) begin
      src = SRC_TMR;
    end
  end
endmodule

// File: rtl/irq_sp.sv
module irq_sp #(
  parameter int             SP_W     = 8,
  parameter int             WIN_W    = 5,
  parameter logic [SP_W-1:0] SP_RESET = 8'hFF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_done,
  input  logic            pop_done,
  output logic [SP_W-1:0] sp,
  output logic [SP_W-1:0] sp_up
);
  localparam int HI_W = SP_W - WIN_W;
  localparam logic [HI_W-1:0] SP_HI = SP_RESET[SP_W-1:WIN_W];

  logic [SP_W-1:0] sp_dn;

  assign sp_up = {SP_HI, sp[WIN_W-1:0] + 1'b1};
  assign sp_dn = {SP_HI, sp[WIN_W-1:0] - 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sp <= SP_RESET;
    else if (push_done) sp <= sp_dn;
    else if (pop_done)  sp <= sp_up;
  end

  p_sp_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sp[SP_W-1:WIN_W] == SP_HI);

  p_step_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_done && pop_done));
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter int          SP_W       = 8,
  parameter int          WIN_W      = 5,
  parameter logic [7:0]  SP_RESET   = 8'hFF,
  parameter logic [15:0] STACK_BASE = 16'h00E0,
  parameter int          IMASK_BIT  = 3,
  parameter logic [15:0] RST_VEC    = 16'h03FE,
  parameter logic [15:0] SWI_VEC    = 16'h03FC,
  parameter logic [15:0] EXT_VEC    = 16'h03FA,
  parameter logic [15:0] TMR_VEC    = 16'h03F8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ext_flag,
  input  logic                ext_en,
  input  logic                ovf_flag,
  input  logic                ovf_en,
  input  logic                rt_flag,
  input  logic                rt_en,
  input  logic                cmd_valid,
  input  logic                cmd_rti,
  output logic                cmd_ready,
  input  logic [DATA_W-1:0]   ccr_in,
  input  logic [DATA_W-1:0]   a_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [2*DATA_W-1:0] pc_in,
  output logic                mem_wr,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  input  logic                mem_ready,
  output logic                busy,
  output logic [SP_W-1:0]     sp_out,
  output logic                ext_clr,
  output logic                done,
  output logic [2*DATA_W-1:0] pc_new,
  output logic                ccr_wr,
  output logic [DATA_W-1:0]   ccr_new,
  output logic                ax_wr,
  output logic [DATA_W-1:0]   a_new,
  output logic [DATA_W-1:0]   x_new
);
  localparam int PC_W      = 2 * DATA_W;
  localparam int CTX_BYTES = 5;
  localparam int STEP_W    = $clog2(CTX_BYTES);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CTX_BYTES - 1);
  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(STACK_BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(STACK_BASE) + ADDR_W'((1 << WIN_W) - 1);
  localparam logic [DATA_W-1:0] IMASK = DATA_W'(1) << IMASK_BIT;

  seq_state_e        state;
  seq_op_e           op;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] vec_base;
  logic [PC_W-1:0]   ctx_pc;
  logic [DATA_W-1:0] ctx_x, ctx_a, ctx_ccr;

  logic              hw_take;
  hw_src_e           hw_src;
  logic [ADDR_W-1:0] hw_vec;
  logic [SP_W-1:0]   sp, sp_up;
  logic              xfer, idle, acc_hw, acc_cmd;

  irq_arbiter #(.ADDR_W(ADDR_W), .EXT_VEC(EXT_VEC), .TMR_VEC(TMR_VEC)) u_arb (
    .ext_flag(ext_flag), .ext_en(ext_en), .ovf_flag(ovf_flag), .ovf_en(ovf_en),
    .rt_flag(rt_flag), .rt_en(rt_en), .gmask(ccr_in[IMASK_BIT]),
    .take(hw_take), .src(hw_src), .vec(hw_vec)
  );

  irq_sp #(.SP_W(SP_W), .WIN_W(WIN_W), .SP_RESET(SP_W'(SP_RESET))) u_sp (
    .clk(clk), .rst_n(rst_n),
    .push_done(state == ST_PUSH && xfer),
    .pop_done(state == ST_POP && xfer),
    .sp(sp), .sp_up(sp_up)
  );

  assign idle      = (state == ST_IDLE);
  assign acc_hw    = idle && hw_take;
  assign acc_cmd   = idle && !hw_take && cmd_valid;
  assign cmd_ready = idle && !hw_take;
  assign ext_clr   = acc_hw && (hw_src == SRC_EXT);
  assign busy      = !idle;
  assign sp_out    = sp;

  assign mem_wr = (state == ST_PUSH);
  assign mem_rd = (state == ST_POP) || (state == ST_VHI) || (state == ST_VLO);
  assign xfer   = (mem_wr || mem_rd) && mem_ready;

  always_comb begin
    case (state)
      ST_PUSH: mem_addr = {{(ADDR_W-SP_W){1'b0}}, sp};
      ST_POP:  mem_addr = {{(ADDR_W-SP_W){1'b0}}, sp_up};
      ST_VLO:  mem_addr = {vec_base[ADDR_W-1:1], 1'b1};
      default: mem_addr = vec_base;
    endcase
    case (step)
      STEP_W'(0): mem_wdata = ctx_pc[DATA_W-1:0];
      STEP_W'(1): mem_wdata = ctx_pc[PC_W-1:DATA_W];
      STEP_W'(2): mem_wdata = ctx_x;
      STEP_W'(3): mem_wdata = ctx_a;
      default:    mem_wdata = ctx_ccr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_BOOT;
      op       <= OP_RESET;
      step     <= '0;
      vec_base <= ADDR_W'(RST_VEC);
      ctx_pc   <= '0;
      ctx_x    <= '0;
      ctx_a    <= '0;
      ctx_ccr  <= '0;
    end else begin
      case (state)
        ST_BOOT: state <= ST_VHI;
        ST_IDLE: if (acc_hw || acc_cmd) begin
          ctx_pc   <= pc_in;
          ctx_x    <= x_in;
          ctx_a    <= a_in;
          ctx_ccr  <= ccr_in;
          step     <= '0;
          vec_base <= acc_hw ? hw_vec : ADDR_W'(SWI_VEC);
          if (acc_cmd && cmd_rti) begin
            op    <= OP_RETURN;
            state <= ST_POP;
          end else begin
            op    <= OP_ENTRY;
            state <= ST_PUSH;
          end
        end
        ST_PUSH: if (xfer) begin
          step <= step + 1'b1;
          if (step == LAST_STEP) state <= ST_VHI;
        end
        ST_POP: if (xfer) begin
          step <= step + 1'b1;
          case (step)
            STEP_W'(0): ctx_ccr <= mem_rdata;
            STEP_W'(1): ctx_a   <= mem_rdata;
            STEP_W'(2): ctx_x   <= mem_rdata;
            STEP_W'(3): ctx_pc[PC_W-1:DATA_W] <= mem_rdata;
            default:    ctx_pc[DATA_W-1:0]    <= mem_rdata;
          endcase
          if (step == LAST_STEP) state <= ST_DONE;
        end
        ST_VHI: if (xfer) begin
          ctx_pc[PC_W-1:DATA_W] <= mem_rdata;
          state <= ST_VLO;
        end
        ST_VLO: if (xfer) begin
          ctx_pc[DATA_W-1:0] <= mem_rdata;
          state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done    = (state == ST_DONE);
  assign pc_new  = ctx_pc;
  assign ccr_wr  = done && (op != OP_RESET);
  assign ax_wr   = done && (op == OP_RETURN);
  assign ccr_new = (op == OP_ENTRY) ? (ctx_ccr | IMASK) : ctx_ccr;
  assign a_new   = ctx_a;
  assign x_new   = ctx_x;

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) && !mem_ready |=>
      $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wr) && $stable(mem_rd));

  p_stack_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr >= WIN_LO) && (mem_addr <= WIN_HI));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_entry_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_wr && !ax_wr |-> ccr_new[IMASK_BIT]);

  p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready && !ext_clr);

  p_ext_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr |=> mem_wr && !ext_clr);
endmodule

// File: tb/irq_stack_seq_bench.sv
module irq_stack_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_flag = 0, ext_en = 0, ovf_flag = 0, ovf_en = 0, rt_flag = 0, rt_en = 0;
  logic cmd_valid = 0, cmd_rti = 0;
  logic [7:0] ccr_in = 8'h08, a_in = 8'h00, x_in = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic mem_ready = 1'b1;
  logic stall = 1'b0;
  logic log_clr = 1'b0;
  logic cmd_ready, mem_wr, mem_rd, busy, ext_clr, done, ccr_wr, ax_wr;
  logic [15:0] mem_addr, pc_new;
  logic [7:0] mem_wdata, mem_rdata, sp_out, ccr_new, a_new, x_new;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_stack_seq u_irq_stack_seq (
    .clk(clk), .rst_n(rst_n), .ext_flag(ext_flag), .ext_en(ext_en),
    .ovf_flag(ovf_flag), .ovf_en(ovf_en), .rt_flag(rt_flag), .rt_en(rt_en),
    .cmd_valid(cmd_valid), .cmd_rti(cmd_rti), .cmd_ready(cmd_ready),
    .ccr_in(ccr_in), .a_in(a_in), .x_in(x_in), .pc_in(pc_in),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .sp_out(sp_out),
    .ext_clr(ext_clr), .done(done), .pc_new(pc_new), .ccr_wr(ccr_wr),
    .ccr_new(ccr_new), .ax_wr(ax_wr), .a_new(a_new), .x_new(x_new)
  );

  // vector bytes at 0x3F8..0x3FF
  function automatic logic [7:0] vbyte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h12; 3'd1: return 8'h34; 3'd2: return 8'h2A; 3'd3: return 8'h5B;
      3'd4: return 8'h3C; 3'd5: return 8'h6D; 3'd6: return 8'h40; default: return 8'h7E;
    endcase
  endfunction

  function automatic logic [15:0] win(input logic [7:0] s, input int off);
    logic [4:0] lo;
    lo = s[4:0] + 5'(off);
    return {8'h00, 3'b111, lo};
  endfunction

  logic [7:0] ram [32];
  assign mem_rdata = (mem_addr[15:3] == 13'h007F) ? vbyte(mem_addr[2:0]) : ram[mem_addr[4:0]];

  logic [15:0] lg_a [64];
  logic [7:0]  lg_d [64];
  logic        lg_w [64];
  int lg_n = 0;
  int clr_cnt = 0;

  always @(posedge clk) begin
    if (log_clr) begin
      lg_n <= 0;
      clr_cnt <= 0;
    end else if (rst_n) begin
      if ((mem_wr || mem_rd) && mem_ready && lg_n < 64) begin
        lg_a[lg_n] <= mem_addr;
        lg_d[lg_n] <= mem_wr ? mem_wdata : mem_rdata;
        lg_w[lg_n] <= mem_wr;
        lg_n <= lg_n + 1;
      end
      if (ext_clr) clr_cnt <= clr_cnt + 1;
    end
    if (rst_n && mem_wr && mem_ready) ram[mem_addr[4:0]] <= mem_wdata;
  end

  always @(negedge clk) mem_ready <= stall ? ~mem_ready : 1'b1;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk) log_clr = 1'b1;
    @(negedge clk) log_clr = 1'b0;
  endtask

  task automatic wait_busy();
    for (int n = 0; n < 40 && !busy; n++) @(negedge clk);
  endtask

  task automatic wait_done(input string req, output int cyc);
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk(req, "done seen", done, 1'b1);
  endtask

  task automatic issue(input logic rti);
    cmd_rti = rti;
    cmd_valid = 1'b1;
    wait_busy();
    cmd_valid = 1'b0;
  endtask

  task automatic check_push(input logic [7:0] sp0, input logic [15:0] pc, input logic [7:0] x, a, c,
                            input logic [15:0] vec, input string req);
    logic [7:0] d [5];
    d[0] = pc[7:0]; d[1] = pc[15:8]; d[2] = x; d[3] = a; d[4] = c;
    chk(req, "transfer count", lg_n, 7);
    for (int k = 0; k < 5; k++)
      chk(req, "push byte", {lg_w[k], lg_a[k], lg_d[k]}, {1'b1, win(sp0, -k), d[k]});
    chk(req, "vector high read", {lg_w[5], lg_a[5], lg_d[5]}, {1'b0, vec, vbyte(vec[2:0])});
    chk(req, "vector low read", {lg_w[6], lg_a[6], lg_d[6]},
        {1'b0, vec | 16'h1, vbyte(vec[2:0] | 3'd1)});
    chk("R6", "entry pc_new", pc_new, {vbyte(vec[2:0]), vbyte(vec[2:0] | 3'd1)});
    chk("R6", "entry ccr_wr/ax_wr", {ccr_wr, ax_wr}, 2'b10);
    chk("R6", "entry ccr_new", ccr_new, c | 8'h08);
  endtask

  task automatic check_pop(input logic [7:0] sp0, input logic [15:0] pc, input logic [7:0] x, a, c,
                           input string req);
    logic [7:0] d [5];
    d[0] = c; d[1] = a; d[2] = x; d[3] = pc[15:8]; d[4] = pc[7:0];
    chk(req, "pop count", lg_n, 5);
    for (int k = 0; k < 5; k++)
      chk(req, "pop byte", {lg_w[k], lg_a[k], lg_d[k]}, {1'b0, win(sp0, k + 1), d[k]});
    chk("R7", "return strobes", {ccr_wr, ax_wr}, 2'b11);
    chk("R7", "restored a/x", {a_new, x_new}, {a, x});
    chk("R7", "restored ccr", ccr_new, c);
    chk("R7", "restored pc", pc_new, pc);
  endtask

  // row: {ext_f, ext_e, ovf_f, ovf_e, rt_f, rt_e, mask, swi, exp[1:0]}; exp 0 none 1 ext 2 timer 3 swi
  localparam logic [9:0] ROWS [9] = '{
    10'b11_00_00_0_0_01,
    10'b00_11_00_0_0_10,
    10'b00_00_11_0_0_10,
    10'b11_11_11_0_1_01,
    10'b10_11_00_0_1_10,
    10'b11_11_00_1_0_00,
    10'b11_11_00_1_1_11,
    10'b10_10_10_0_0_00,
    10'b01_01_01_0_1_11
  };

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [15:0] vec;
    logic [7:0] cc;
    logic [7:0] sp0;

    // R1: reset state and reset vector fetch
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "sp after reset", sp_out, 8'hFF);
    chk("R1", "busy during boot", busy, 1'b1);
    wait_done("R1", cyc);
    chk("R1", "reset pc", pc_new, 16'h407E);
    chk("R1", "no register loads", {ccr_wr, ax_wr}, 2'b00);
    chk("R1", "boot reads", {lg_n[7:0], lg_w[0], lg_a[0], lg_w[1], lg_a[1]},
        {8'd2, 1'b0, 16'h03FE, 1'b0, 16'h03FF});
    @(negedge clk);
    chk("R11", "ready when idle", cmd_ready, 1'b1);

    // table walk: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < 9; i++) begin
      clear_log();
      cc = {4'hE, ROWS[i][3], 3'(i)};
      ccr_in = cc;
      pc_in = 16'hA000 + 16'(i * 16'h111);
      x_in = 8'h10 + 8'(i);
      a_in = 8'h80 + 8'(i);
      {ext_flag, ext_en, ovf_flag, ovf_en, rt_flag, rt_en} = ROWS[i][9:4];
      cmd_rti = 1'b0;
      cmd_valid = ROWS[i][2];
      if (ROWS[i][1:0] == 2'd0) begin
        repeat (8) @(negedge clk);
        chk("R3", "no request taken", {busy, lg_n[7:0]}, 9'd0);
        chk("R4", "command side free", cmd_ready, 1'b1);
        chk("R10", "no latch clear", clr_cnt, 0);
        {ext_flag, ovf_flag, rt_flag} = 3'b000;
      end else begin
        wait_busy();
        cmd_valid = 1'b0;
        wait_done("R2", cyc);
        vec = (ROWS[i][1:0] == 2'd1) ? 16'h03FA : (ROWS[i][1:0] == 2'd2) ? 16'h03F8 : 16'h03FC;
        check_push(8'hFF, pc_in, x_in, a_in, cc, vec, "R2/R5");
        chk("R10", "latch clear count", clr_cnt, (ROWS[i][1:0] == 2'd1) ? 1 : 0);
        chk("R5", "sp after push", sp_out, 8'hFA);
        ccr_in = ccr_new;
        {ext_flag, ovf_flag, rt_flag} = 3'b000;
        clear_log();
        issue(1'b1);
        wait_done("R7", cyc);
        check_pop(8'hFA, 16'hA000 + 16'(i * 16'h111), 8'h10 + 8'(i), 8'h80 + 8'(i), cc, "R7");
        chk("R7", "sp after pop", sp_out, 8'hFF);
        ccr_in = ccr_new;
      end
      cmd_valid = 1'b0;
    end

    // R11: request raised mid-sequence with mask clear is not taken
    clear_log();
    ccr_in = 8'h00;
    pc_in = 16'h5A5A; x_in = 8'h33; a_in = 8'h44;
    issue(1'b0);
    ext_flag = 1'b1; ext_en = 1'b1;
    @(negedge clk);
    chk("R11", "ready low while busy", cmd_ready, 1'b0);
    wait_done("R11", cyc);
    check_push(8'hFF, 16'h5A5A, 8'h33, 8'h44, 8'h00, 16'h03FC, "R11");
    chk("R11", "no latch clear mid-sequence", clr_cnt, 0);
    ccr_in = ccr_new;
    repeat (5) @(negedge clk);
    chk("R11", "masked after entry", {busy, lg_n[7:0]}, {1'b0, 8'd7});
    ext_flag = 1'b0; ext_en = 1'b0;
    clear_log();
    issue(1'b1);
    wait_done("R7", cyc);
    ccr_in = 8'h08;

    // R9: back-pressure keeps frame identical and takes longer
    stall = 1'b1;
    clear_log();
    pc_in = 16'hBEEF; x_in = 8'h5C; a_in = 8'hC5;
    issue(1'b0);
    wait_done("R9", cyc);
    check_push(8'hFF, 16'hBEEF, 8'h5C, 8'hC5, 8'h08, 16'h03FC, "R9");
    chk("R9", "stalled sequence longer", (cyc >= 10) ? 1 : 0, 1);
    ccr_in = ccr_new;
    clear_log();
    issue(1'b1);
    wait_done("R9", cyc);
    check_pop(8'hFA, 16'hBEEF, 8'h5C, 8'hC5, 8'h08, "R9");
    stall = 1'b0;
    ccr_in = 8'h08;

    // R8: seven nested entries wrap the 32-byte window
    for (int n = 0; n < 7; n++) begin
      clear_log();
      sp0 = {3'b111, 5'(31 - 5 * n)};
      pc_in = 16'hC000 + 16'(n); x_in = 8'(n); a_in = ~8'(n);
      issue(1'b0);
      wait_done("R8", cyc);
      if (n == 6) check_push(sp0, pc_in, x_in, a_in, 8'h08, 16'h03FC, "R8");
      else chk("R8", "nested transfer count", lg_n, 7);
    end
    chk("R8", "sp after wrap", sp_out, 8'hFC);
    clear_log();
    issue(1'b1);
    wait_done("R8", cyc);
    check_pop(8'hFC, 16'hC006, 8'h06, 8'hF9, 8'h08, "R8");
    chk("R8", "sp after wrapped pop", sp_out, 8'hE1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule